// File: doc/BRIEF.md
# Bank-Selective Ternary CAM

This block is a ternary content-addressable memory built entirely from flip-flops and gate logic. Each entry stores a value, a care mask and a valid bit. A key bit is compared with the stored bit only where the care bit is set. Where the care bit is clear, the stored bit is a don't-care and matches either key value.

The entries are split into equal banks. The most significant bits of every search key are classifier bits, and they name the single bank whose comparators are enabled for that search. The comparators of every other bank stay idle. The match-vector bits of those other banks therefore read zero, whatever those entries hold.

The write port loads the value and care mask into one addressed entry and marks it valid. The search port accepts a key with a valid strobe. One cycle later the block presents registered results with a result strobe:
- the per-entry match vector,
- a hit flag,
- the index of the lowest-numbered matching entry.

Software is expected to place rules in the bank that matches their classifier bits.

Top module: `bstcam`

## Requirements
- R1: After the synchronous reset, every entry is invalid and res_valid, res_hit, res_addr and res_match are all zero. A search made before any write misses.
- R2: When wr_en is high at a clock edge, that edge loads wr_value and wr_care into entry wr_addr and marks the entry valid. A search in a later cycle sees the new contents. A search in the same cycle as the write sees the contents from before the write.
- R3: A key bit whose stored care bit is 1 must equal the stored value bit. A key bit whose care bit is 0 matches either key value.
- R4: The selected bank is key[WIDTH-1 -: log2(BANKS)], which is key[35:34] by default. Entry i belongs to bank i / (ENTRIES/BANKS), so entries 0-15 form bank 0 and entries 48-63 form bank 3. Only entries of the selected bank are compared.
- R5: res_match bits of unselected banks are zero, even when those entries hold valid contents that would match the key.
- R6: res_valid is high exactly in the cycle after a cycle with srch_valid high. res_match, res_hit and res_addr change only on the edge that captures a search, and otherwise hold their values.
- R7: res_hit is the OR of res_match. res_addr is the lowest index set in res_match, and it is zero when res_hit is low.
- R8: An entry that has not been written since reset never matches, even a key that would match any contents.
- R9: Writing an entry again replaces its previous value and care mask completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Entry index to write |
| wr_value | input | 36 | Value to store |
| wr_care | input | 36 | Care mask, 1 = bit compared |
| srch_valid | input | 1 | Search strobe |
| srch_key | input | 36 | Search key, top 2 bits select the bank |
| res_valid | output | 1 | Result strobe, one cycle after srch_valid |
| res_match | output | 64 | Per-entry match vector |
| res_hit | output | 1 | At least one entry matched |
| res_addr | output | 6 | Lowest matching entry index |

## Verification
The hardest case to reach from the ports is a valid entry in an unselected bank whose stored contents match the key. Reaching it needs a rule whose classifier bits are don't-care, placed outside the bank that the key names. The directed sequence builds this case on purpose. It stores such a rule in bank 1 and searches with a bank 0 key. It then checks that the bank 1 bit stays low, and that the same key with bank 1 classifier bits does hit it. Random traffic then derives keys from stored rules, so multi-entry matches, misses caused by a bank mismatch, and writes in the same cycle as searches all occur often. A behavioural model is compared with the outputs on every clock.

// File: rtl/bstcam_pkg.sv
package bstcam_pkg;
  localparam int DEF_ENTRIES = 64;
  localparam int DEF_WIDTH   = 36;
  localparam int DEF_BANKS   = 4;

  // bank that owns a given entry index
  function automatic int bank_of(input int idx, input int per_bank);
    return idx / per_bank;
  endfunction
endpackage

// File: rtl/bstcam_entry.sv
module bstcam_entry #(
  parameter int WIDTH = 36
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_sel,
  input  logic [WIDTH-1:0] wr_value,
  input  logic [WIDTH-1:0] wr_care,
  input  logic             cmp_en,
  input  logic [WIDTH-1:0] key,
  output logic             match
);
  logic             vld_q;
  logic [WIDTH-1:0] val_q;
  logic [WIDTH-1:0] care_q;
  logic [WIDTH-1:0] diff;

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else if (wr_sel) vld_q <= 1'b1;
  end

  // data registers carry no reset; the valid bit qualifies them
  always_ff @(posedge clk) begin
    if (wr_sel) begin
      val_q  <= wr_value;
      care_q <= wr_care;
    end
  end

  // comparison is gated: a disabled entry never toggles its result
  always_comb begin
    diff  = (key ^ val_q) & care_q;
    match = cmp_en & vld_q & ~(|diff);
  end
endmodule

// File: rtl/bstcam_bank_sel.sv
module bstcam_bank_sel #(
  parameter int WIDTH = 36,
  parameter int BANKS = 4
) (
  input  logic [WIDTH-1:0] key,
  input  logic             enable,
  output logic [BANKS-1:0] bank_en
);
  generate
    if (BANKS == 1) begin : g_single
      assign bank_en = enable;
    end else begin : g_multi
      localparam int SEL_W = $clog2(BANKS);
      logic [SEL_W-1:0] sel;
      assign sel = key[WIDTH-1 -: SEL_W];
      always_comb begin
        bank_en = '0;
        for (int b = 0; b < BANKS; b++)
          if (sel == SEL_W'(b)) bank_en[b] = enable;
      end
    end
  endgenerate
endmodule

// File: rtl/bstcam_prio.sv
module bstcam_prio #(
  parameter int N = 64
) (
  input  logic [N-1:0]         vec,
  output logic                 any,
  output logic [$clog2(N)-1:0] idx
);
  localparam int IW = $clog2(N);

  // scan downward so the lowest set index is the last one assigned
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (vec[i]) idx = IW'(i);
  end
endmodule

// File: rtl/bstcam.sv
module bstcam
  import bstcam_pkg::*;
#(
  parameter int ENTRIES = DEF_ENTRIES,
  parameter int WIDTH   = DEF_WIDTH,
  parameter int BANKS   = DEF_BANKS,
  localparam int ADDR_W   = $clog2(ENTRIES),
  localparam int PER_BANK = ENTRIES / BANKS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [WIDTH-1:0]   wr_value,
  input  logic [WIDTH-1:0]   wr_care,
  input  logic               srch_valid,
  input  logic [WIDTH-1:0]   srch_key,
  output logic               res_valid,
  output logic [ENTRIES-1:0] res_match,
  output logic               res_hit,
  output logic [ADDR_W-1:0]  res_addr
);
  logic [BANKS-1:0]   bank_en;
  logic [ENTRIES-1:0] raw_match;
  logic               raw_hit;
  logic [ADDR_W-1:0]  raw_addr;

  bstcam_bank_sel #(.WIDTH(WIDTH), .BANKS(BANKS)) u_bank_sel (
    .key     (srch_key),
    .enable  (srch_valid),
    .bank_en (bank_en)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    localparam int BK = bank_of(i, PER_BANK);
    logic wsel;
    assign wsel = wr_en && (wr_addr == ADDR_W'(i));
    bstcam_entry #(.WIDTH(WIDTH)) u_entry (
      .clk      (clk),
      .rst      (rst),
      .wr_sel   (wsel),
      .wr_value (wr_value),
      .wr_care  (wr_care),
      .cmp_en   (bank_en[BK]),
      .key      (srch_key),
      .match    (raw_match[i])
    );
  end

  bstcam_prio #(.N(ENTRIES)) u_prio (
    .vec (raw_match),
    .any (raw_hit),
    .idx (raw_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_match <= '0;
      res_hit   <= 1'b0;
      res_addr  <= '0;
    end else begin
      res_valid <= srch_valid;
      if (srch_valid) begin
        res_match <= raw_match;
        res_hit   <= raw_hit;
        res_addr  <= raw_addr;
      end
    end
  end
endmodule

// File: rtl/bstcam_chk.sv
module bstcam_chk #(
  parameter int ENTRIES = 64,
  parameter int WIDTH   = 36,
  parameter int BANKS   = 4,
  localparam int ADDR_W   = $clog2(ENTRIES),
  localparam int PER_BANK = ENTRIES / BANKS,
  localparam int SEL_W    = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               srch_valid,
  input logic [WIDTH-1:0]   srch_key,
  input logic               res_valid,
  input logic [ENTRIES-1:0] res_match,
  input logic               res_hit,
  input logic [ADDR_W-1:0]  res_addr
);
  logic [WIDTH-1:0]   key_q;
  logic [ENTRIES-1:0] bank_mask;
  logic [ENTRIES-1:0] below_mask;
  int                 bank_idx;

  always_ff @(posedge clk)
    if (srch_valid) key_q <= srch_key;

  always_comb begin
    bank_idx   = (BANKS > 1) ? int'(key_q[WIDTH-1 -: SEL_W]) : 0;
    bank_mask  = ENTRIES'({PER_BANK{1'b1}}) << (bank_idx * PER_BANK);
    below_mask = (ENTRIES'(1) << res_addr) - ENTRIES'(1);
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!res_valid && !res_hit && res_match == '0));

  p_bank_iso_r5: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ((res_match & ~bank_mask) == '0));

  p_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    srch_valid |=> res_valid);

  p_no_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    !srch_valid |=> !res_valid);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !srch_valid |=> ($stable(res_match) && $stable(res_addr) && $stable(res_hit)));

  p_hit_or_r7: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_hit == (res_match != '0)));

  p_miss_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_addr == '0));

  p_lowest_r7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_hit) |-> (res_match[res_addr] && (res_match & below_mask) == '0));
endmodule

bind bstcam bstcam_chk #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .BANKS(BANKS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .srch_valid (srch_valid),
  .srch_key   (srch_key),
  .res_valid  (res_valid),
  .res_match  (res_match),
  .res_hit    (res_hit),
  .res_addr   (res_addr)
);

// File: tb/bstcam_tb.sv
`timescale 1ns/1ps
module bstcam_tb;
  localparam int N  = 64;
  localparam int W  = 36;
  localparam int PB = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [5:0]    wr_addr = '0;
  logic [W-1:0]  wr_value = '0;
  logic [W-1:0]  wr_care = '0;
  logic          srch_valid = 1'b0;
  logic [W-1:0]  srch_key = '0;
  logic          res_valid;
  logic [N-1:0]  res_match;
  logic          res_hit;
  logic [5:0]    res_addr;

  always #2.5 clk = ~clk;

  bstcam u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_value(wr_value), .wr_care(wr_care), .srch_valid(srch_valid),
    .srch_key(srch_key), .res_valid(res_valid), .res_match(res_match),
    .res_hit(res_hit), .res_addr(res_addr)
  );

  int checks = 0;
  int fails  = 0;
  bit started = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [W-1:0] m_val  [N];
  logic [W-1:0] m_care [N];
  bit           m_vld  [N];
  logic         e_valid;
  logic [N-1:0] e_match;
  logic         e_hit;
  logic [5:0]   e_addr;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      foreach (m_vld[i]) m_vld[i] = 0;
      e_valid = 0; e_match = '0; e_hit = 0; e_addr = '0;
    end else begin
      e_valid = srch_valid;
      if (srch_valid) begin
        e_match = '0;
        for (int i = 0; i < N; i++)
          if (m_vld[i] && (i / PB) == int'(srch_key[W-1:W-2]) &&
              ((srch_key ^ m_val[i]) & m_care[i]) == '0)
            e_match[i] = 1'b1;
        e_hit = (e_match != '0);
        e_addr = '0;
        for (int i = N - 1; i >= 0; i--) if (e_match[i]) e_addr = 6'(i);
      end
      if (wr_en) begin
        m_val[wr_addr]  = wr_value;
        m_care[wr_addr] = wr_care;
        m_vld[wr_addr]  = 1;
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      check(res_valid == e_valid, "R6 res_valid", 64'(res_valid), 64'(e_valid));
      check(res_match == e_match, "R4 res_match", res_match, e_match);
      check(res_hit == e_hit, "R7 res_hit", 64'(res_hit), 64'(e_hit));
      check(res_addr == e_addr, "R7 res_addr", 64'(res_addr), 64'(e_addr));
    end
  end

  task automatic wr(input int a, input logic [W-1:0] v, input logic [W-1:0] c);
    wr_en = 1; wr_addr = 6'(a); wr_value = v; wr_care = c;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic srch(input logic [W-1:0] k, input bit eh, input int ea, input string tag);
    srch_valid = 1; srch_key = k;
    @(negedge clk);
    srch_valid = 0;
    check(res_hit == eh, tag, 64'(res_hit), 64'(eh));
    check(res_addr == 6'(ea), tag, 64'(res_addr), 64'(ea));
  endtask

  localparam logic [W-1:0] ONES = '1;

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(res_valid == 0 && res_match == '0, "R1 reset outputs", 64'(res_valid), 64'h0);
    srch(36'h0_0000_0000, 0, 0, "R1 search before any write");

    wr(3, 36'h0_1234_5678, ONES);
    srch(36'h0_1234_5678, 1, 3, "R2 written entry found");
    srch(36'h0_1234_5679, 0, 0, "R3 care bit mismatch");

    wr(1, 36'h0_1234_5600, 36'hF_FFFF_FF00);
    srch(36'h0_1234_5678, 1, 1, "R7 lowest of two matches");
    srch(36'h0_1234_56AB, 1, 1, "R3 dont-care low byte");

    wr(20, 36'h0_1234_5678, 36'h3_FFFF_FFFF);
    srch(36'h0_1234_5678, 1, 1, "R5 bank0 key");
    check(res_match[20] == 0, "R5 other bank bit", 64'(res_match[20]), 64'h0);
    srch(36'h4_1234_5678, 1, 20, "R4 bank1 key selects entry 20");

    srch(36'hC_ABCD_0123, 0, 0, "R8 unwritten bank misses");
    wr(48, 36'h0, 36'h0);
    srch(36'hC_ABCD_0123, 1, 48, "R8 entry 48 now valid");

    wr(1, 36'h0_0000_0001, ONES);
    srch(36'h0_1234_56AB, 0, 0, "R9 overwritten entry gone");
    srch(36'h0_1234_5678, 1, 3, "R9 remaining entry 3");

    // write and search in the same cycle
    wr_en = 1; wr_addr = 6'd0; wr_value = 36'h0_1234_5678; wr_care = ONES;
    srch(36'h0_1234_5678, 1, 3, "R2 same-cycle search sees old contents");
    wr_en = 0;
    srch(36'h0_1234_5678, 1, 0, "R2 next search sees new entry");

    // random traffic checked by the per-clock model comparison
    for (int n = 0; n < 3000; n++) begin
      wr_en = ($urandom_range(0, 2) == 0);
      wr_addr = 6'($urandom_range(0, N - 1));
      wr_value = W'({$urandom(), $urandom()});
      wr_value[W-1:W-2] = ($urandom_range(0, 7) == 0) ? 2'($urandom()) : wr_addr[5:4];
      wr_care = W'({$urandom(), $urandom()}) | W'({$urandom(), $urandom()});
      if ($urandom_range(0, 5) == 0) wr_care = '0;
      srch_valid = ($urandom_range(0, 3) != 0);
      begin
        int idx = $urandom_range(0, N - 1);
        logic [W-1:0] r = W'({$urandom(), $urandom()});
        srch_key = m_vld[idx] ? ((m_val[idx] & m_care[idx]) | (r & ~m_care[idx])) : r;
        if ($urandom_range(0, 3) == 0) srch_key[W-1:W-2] = 2'($urandom());
      end
      @(negedge clk);
    end
    wr_en = 0; srch_valid = 0;
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule